// File: doc/BRIEF.md
# Critical Address Range Register Unit

This block holds a small set of software-programmable address windows that mark memory regions as critical for a criticality-aware cache. Each window has a 32-bit lower bound, a 32-bit inclusive upper bound and an enable bit. Every cache access address is compared against all enabled windows at once, and the result is a single critical flag. The cache replacement logic uses this flag to decide whether the line being filled or evicted counts as critical.

Software reaches the windows through a simple word-indexed register port with an index, write data, a write strobe and combinational read data. One register index is a write-only trigger. Any write to it produces a single-cycle clear pulse that tells the replacement unit to zero its per-set critical-line counts. Software issues this pulse before it reprograms the windows. If software disables or clears every window and then issues the pulse, the cache falls back to plain least-recently-used replacement.

Top module: `crit_range_regs`

## Requirements
- R1: After reset every window bound and every enable bit is zero, the critical flag is low for any address, and the clear pulse is low.
- R2: Register indices, with N windows: window k lower bound at index 2k, window k upper bound at index 2k+1, the enable register at index 2N (bit k enables window k, and higher bits read zero), and the clear trigger at index 2N+1. Any other index reads zero, and writes to it change nothing.
- R3: A write to a bound or to the enable register is visible on read data from the cycle after the write strobe. Read data is combinational from the index.
- R4: An address is critical when, for at least one enabled window, it is at least that window's lower bound and at most its upper bound. Both ends are inclusive.
- R5: A window whose enable bit is zero never makes an address critical.
- R6: A window whose upper bound is below its lower bound never matches any address.
- R7: The critical flag follows the access address combinationally in the same cycle.
- R8: Each write to the clear trigger gives exactly one clear pulse, high during the cycle after the write strobe, whatever the written data. The pulse is never high in a cycle that does not follow such a write.
- R9: The clear trigger reads zero, and a write to it leaves all window bounds and enable bits unchanged.
- R10: When all windows are disabled and their bounds are cleared, no address is critical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | IDX_W | Register word index |
| reg_wdata | input | DATA_W | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | DATA_W | Register read data, combinational |
| acc_addr | input | DATA_W | Cache access address |
| acc_crit | output | 1 | Address lies in an enabled window |
| crit_clear | output | 1 | One-cycle clear pulse for the critical-line counts |

## Verification
The critical flag and read data are combinational, so the bench changes the address or index on a falling edge and samples 1 ns later in the same cycle. Register contents change at the rising edge that ends the write strobe, so readback and match checks run only after that edge. The clear pulse is registered once, so it is sampled on the falling edge right after the write strobe ends, and again one cycle later to confirm that it has dropped. Range matching is swept over all sixteen enable masks, with probes one below, at, and one above each window edge, including wrap-around at the ends of the address space.

// File: rtl/crit_range_pkg.sv
package crit_range_pkg;

   typedef enum logic [2:0] {
      RK_BASE  = 3'd0,
      RK_LIMIT = 3'd1,
      RK_CTRL  = 3'd2,
      RK_SRST  = 3'd3,
      RK_NONE  = 3'd4
   } reg_kind_e;

   // Classify a register index for a bank of n windows.
   function automatic reg_kind_e kind_of(input int unsigned idx, input int unsigned n);
      if (idx < 2 * n)       return (idx % 2 == 0) ? RK_BASE : RK_LIMIT;
      else if (idx == 2 * n) return RK_CTRL;
      else if (idx == 2 * n + 1) return RK_SRST;
      else                   return RK_NONE;
   endfunction

   function automatic int unsigned slot_of(input int unsigned idx);
      return idx / 2;
   endfunction

endpackage

// File: rtl/crit_range_bank.sv
module crit_range_bank
   import crit_range_pkg::*;
#(
   parameter int unsigned N     = 4,
   parameter int unsigned DW    = 32,
   parameter int unsigned IW    = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [IW-1:0]          reg_idx,
   input  logic [DW-1:0]          reg_wdata,
   input  logic                   reg_we,
   output logic [DW-1:0]          reg_rdata,
   output logic [N-1:0][DW-1:0]   base_o,
   output logic [N-1:0][DW-1:0]   lim_o,
   output logic [N-1:0]           en_o
);
   localparam int unsigned CTRL_IDX = 2 * N;

   logic [N-1:0][DW-1:0] base_q;
   logic [N-1:0][DW-1:0] lim_q;
   logic [N-1:0]         en_q;

   for (genvar k = 0; k < N; k++) begin : g_win
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[k] <= '0;
            lim_q[k]  <= '0;
         end else if (reg_we) begin
            if (reg_idx == IW'(2 * k))     base_q[k] <= reg_wdata;
            if (reg_idx == IW'(2 * k + 1)) lim_q[k]  <= reg_wdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                en_q <= '0;
      else if (reg_we && reg_idx == IW'(CTRL_IDX)) en_q <= reg_wdata[N-1:0];
   end

   always_comb begin
      reg_rdata = '0;
      unique case (kind_of(int'(reg_idx), N))
         RK_BASE:  reg_rdata = base_q[slot_of(int'(reg_idx))];
         RK_LIMIT: reg_rdata = lim_q[slot_of(int'(reg_idx))];
         RK_CTRL:  reg_rdata[N-1:0] = en_q;
         default:  reg_rdata = '0;
      endcase
   end

   assign base_o = base_q;
   assign lim_o  = lim_q;
   assign en_o   = en_q;
endmodule

// File: rtl/crit_range_match.sv
module crit_range_match #(
   parameter int unsigned DW = 32
) (
   input  logic [DW-1:0] addr,
   input  logic [DW-1:0] lo,
   input  logic [DW-1:0] hi,
   input  logic          en,
   output logic          hit
);
   logic above_lo, below_hi;
   assign above_lo = (addr >= lo);
   assign below_hi = (addr <= hi);
   assign hit      = en & above_lo & below_hi;
endmodule

// File: rtl/crit_range_pulse.sv
module crit_range_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= fire;
   end
endmodule

// File: rtl/crit_range_regs.sv
module crit_range_regs
   import crit_range_pkg::*;
#(
   parameter int unsigned NUM_RANGES = 4,
   parameter int unsigned DATA_W     = 32,
   localparam int unsigned IDX_W     = $clog2(2 * NUM_RANGES + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_we,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [DATA_W-1:0] acc_addr,
   output logic              acc_crit,
   output logic              crit_clear
);
   localparam int unsigned SRST_IDX = 2 * NUM_RANGES + 1;

   if (NUM_RANGES < 1 || NUM_RANGES > 16) begin : g_bad_n
      $error("NUM_RANGES must be 1..16");
   end
   if (DATA_W < 8 || DATA_W < NUM_RANGES) begin : g_bad_w
      $error("DATA_W must be at least 8 and at least NUM_RANGES");
   end

   logic [NUM_RANGES-1:0][DATA_W-1:0] base_w;
   logic [NUM_RANGES-1:0][DATA_W-1:0] lim_w;
   logic [NUM_RANGES-1:0]             en_q;
   logic [NUM_RANGES-1:0]             hit_w;
   logic                              srst_fire;

   crit_range_bank #(.N(NUM_RANGES), .DW(DATA_W), .IW(IDX_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_idx   (reg_idx),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_rdata (reg_rdata),
      .base_o    (base_w),
      .lim_o     (lim_w),
      .en_o      (en_q)
   );

   for (genvar k = 0; k < NUM_RANGES; k++) begin : g_cmp
      crit_range_match #(.DW(DATA_W)) u_match (
         .addr (acc_addr),
         .lo   (base_w[k]),
         .hi   (lim_w[k]),
         .en   (en_q[k]),
         .hit  (hit_w[k])
      );
   end

   assign acc_crit  = |hit_w;
   assign srst_fire = reg_we && (reg_idx == IDX_W'(SRST_IDX));

   crit_range_pulse u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (srst_fire),
      .pulse (crit_clear)
   );
endmodule

// File: rtl/crit_range_chk.sv
module crit_range_chk #(
   parameter int unsigned N  = 4,
   parameter int unsigned DW = 32,
   parameter int unsigned IW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [IW-1:0] reg_idx,
   input logic [DW-1:0] reg_wdata,
   input logic          reg_we,
   input logic [DW-1:0] reg_rdata,
   input logic          acc_crit,
   input logic          crit_clear,
   input logic [N-1:0]  en_q
);
   localparam logic [IW-1:0] CTRL_I = IW'(2 * N);
   localparam logic [IW-1:0] SRST_I = IW'(2 * N + 1);

   a_r8_pulse_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_idx == SRST_I) |=> crit_clear);

   a_r8_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_idx == SRST_I) |=> !crit_clear);

   a_r5_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      acc_crit |-> (en_q != '0));

   a_r3_enable_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_idx == CTRL_I) |=> (en_q == $past(reg_wdata[N-1:0])));

   a_r9_trigger_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_idx == SRST_I) |-> (reg_rdata == '0));
endmodule

bind crit_range_regs crit_range_chk #(.N(NUM_RANGES), .DW(DATA_W), .IW(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_idx    (reg_idx),
   .reg_wdata  (reg_wdata),
   .reg_we     (reg_we),
   .reg_rdata  (reg_rdata),
   .acc_crit   (acc_crit),
   .crit_clear (crit_clear),
   .en_q       (en_q)
);

// File: tb/test_crit_range_regs.sv
`timescale 1ns/1ps
module test_crit_range_regs;
   localparam int N = 4;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [IW-1:0] reg_idx = '0;
   logic [31:0]   reg_wdata = '0;
   logic          reg_we = 1'b0;
   logic [31:0]   reg_rdata;
   logic [31:0]   acc_addr = '0;
   logic          acc_crit;
   logic          crit_clear;

   int total = 0;
   int bad = 0;

   logic [31:0] mb [N];
   logic [31:0] ml [N];
   logic [N-1:0] men;

   always #10 clk = ~clk;

   crit_range_regs i_crit_range_regs (
      .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .acc_addr(acc_addr),
      .acc_crit(acc_crit), .crit_clear(crit_clear));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   function automatic logic model_crit(input logic [31:0] a);
      for (int k = 0; k < N; k++)
         if (men[k] && a >= mb[k] && a <= ml[k]) return 1'b1;
      return 1'b0;
   endfunction

   // drive on falling edge; returns on the falling edge after the write edge
   task automatic wr(input int idx, input logic [31:0] d);
      @(negedge clk);
      reg_idx = IW'(idx); reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      if (idx < 2 * N) begin
         if (idx % 2 == 0) mb[idx/2] = d; else ml[idx/2] = d;
      end else if (idx == 2 * N) men = d[N-1:0];
   endtask

   task automatic rd_chk(input string req, input int idx, input logic [31:0] exp);
      reg_idx = IW'(idx);
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic probe(input string req, input logic [31:0] a);
      acc_addr = a;
      #1;
      chk(req, {31'd0, acc_crit}, {31'd0, model_crit(a)});
   endtask

   task automatic readback_all(input string req);
      for (int i = 0; i < 2 * N; i++)
         rd_chk(req, i, (i % 2 == 0) ? mb[i/2] : ml[i/2]);
      rd_chk(req, 2 * N, {28'd0, men});
   endtask

   initial begin
      for (int k = 0; k < N; k++) begin mb[k] = '0; ml[k] = '0; end
      men = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      readback_all("R1 reset regs");
      chk("R1 reset pulse", {31'd0, crit_clear}, 32'd0);
      probe("R1 reset addr0", 32'h0);
      probe("R1 reset addrmax", 32'hFFFF_FFFF);

      // R3: readback of written bounds
      begin
         logic [31:0] lf = 32'hACE1_1234;
         for (int i = 0; i < 2 * N; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            wr(i, lf);
         end
      end
      readback_all("R3 readback");

      // R2: enable register upper bits read zero
      wr(2 * N, 32'hFFFF_FFFF);
      rd_chk("R2 ctrl width", 2 * N, 32'h0000_000F);
      // R2: unmapped indices ignored
      for (int i = 2 * N + 2; i < 16; i++) wr(i, 32'hDEAD_BEEF);
      readback_all("R2 unmapped write ignored");
      for (int i = 2 * N + 2; i < 16; i++) rd_chk("R2 unmapped reads zero", i, 32'h0);

      // program windows: normal, single address, top of space, inverted
      wr(0, 32'h0000_1000); wr(1, 32'h0000_1FFF);
      wr(2, 32'h8000_0000); wr(3, 32'h8000_0000);
      wr(4, 32'hFFFF_F000); wr(5, 32'hFFFF_FFFF);
      wr(6, 32'h0000_5000); wr(7, 32'h0000_4000);

      // R4 R5 R6 R7: sweep all enable masks with edge probes
      for (int m = 0; m < 16; m++) begin
         wr(2 * N, 32'(m));
         for (int k = 0; k < N; k++) begin
            probe("R4 below lo", mb[k] - 32'd1);
            probe("R4 at lo", mb[k]);
            probe("R4 at hi", ml[k]);
            probe("R4 above hi", ml[k] + 32'd1);
         end
         probe("R6 inverted gap", 32'h0000_4800);
         probe("R5 outside", 32'h4000_0000);
         // R7: same-cycle response to address change
         acc_addr = 32'h0000_1800; #1;
         chk("R7 comb", {31'd0, acc_crit}, {31'd0, m[0]});
      end

      // R8: pulse per trigger write, any data
      wr(2 * N + 1, 32'h0);
      chk("R8 pulse zero data", {31'd0, crit_clear}, 32'd1);
      @(negedge clk);
      chk("R8 pulse single", {31'd0, crit_clear}, 32'd0);
      wr(2 * N + 1, 32'hFFFF_FFFF);
      chk("R8 pulse ones data", {31'd0, crit_clear}, 32'd1);
      @(negedge clk);
      chk("R8 pulse drops", {31'd0, crit_clear}, 32'd0);
      wr(0, 32'h0000_1000);
      chk("R8 no pulse other write", {31'd0, crit_clear}, 32'd0);

      // R9: trigger reads zero, leaves registers alone
      rd_chk("R9 trigger reads zero", 2 * N + 1, 32'h0);
      readback_all("R9 regs unchanged");

      // R10: clear everything, then no address critical
      for (int i = 0; i < 2 * N; i++) wr(i, 32'h0);
      wr(2 * N, 32'h0);
      wr(2 * N + 1, 32'h1);
      probe("R10 addr0", 32'h0);
      probe("R10 addr mid", 32'h0000_1800);
      probe("R10 addr max", 32'hFFFF_FFFF);
      chk("R10 flag low", {31'd0, acc_crit}, 32'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog got=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule